// File: doc/BRIEF.md
# Process-Selective TLB Flush Scanner

This engine removes every translation that belongs to one process from the page caches that sit downstream of a pair of TLBs (instruction and data). After a start pulse carrying a process ID, it walks every entry of both TLBs, one entry per clock, through a read port into TLB storage. It picks out the entries whose process tag equals the requested ID and that are both valid and not global. For each such entry it sends out the virtual page address stored in that entry as a page-invalidate request.

The TLB contents are only read, never written. The invalidate requests leave on a valid/ready stream. While a request waits for acceptance, the walk stops on the current entry. A busy flag covers the whole walk, and a one-cycle done pulse follows it. With the default parameters the walk covers 2 TLBs × 4 ways × 16 sets, which is 128 entries, so an unstalled walk takes exactly 128 busy cycles.

Top module: `pid_flush_scanner`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `inv_valid` are low.
- R2: A `start` pulse seen while `busy` is low starts a walk, and `busy` is high from the next cycle. Only bits 7:0 of `start_pid` are used as the process ID. Bits 31:8 have no effect on which entries are selected.
- R3: The walk visits entries in the order TLB outermost, then way, then set innermost. The visited entry is shown on `rd_tlb`, `rd_way` and `rd_set`, and `rd_hi`/`rd_lo` are expected to hold that entry's words in the same cycle. Without stalls the walk advances one entry per cycle, so `busy` lasts exactly 128 cycles, plus one cycle for each stalled cycle.
- R4: An entry produces a request if and only if `rd_lo[3]` (valid) is 1, `rd_lo[4]` (global) is 0, and `rd_hi[7:0]` equals the requested ID. Other entries produce no request.
- R5: The request address is `rd_hi[31:13]` placed at bits 31:13, with bits 12:0 zero.
- R6: While `inv_valid` is high and `inv_ready` is low, the next cycle keeps `inv_valid` high with the same `inv_addr`, and the read address does not move.
- R7: After the last entry has been examined, `busy` falls and `done` is high for exactly one cycle, with `busy` low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored. It does not change the ID in use or the walk position, and it does not start another walk afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| start_pid | input | 32 | Process ID register value; low 8 bits used |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at end of walk |
| rd_tlb | output | 1 | Read port: TLB select (0 instruction, 1 data) |
| rd_way | output | 2 | Read port: way select |
| rd_set | output | 4 | Read port: set select |
| rd_hi | input | 32 | Entry high word (page number, process tag) |
| rd_lo | input | 32 | Entry low word (global, valid and other flags) |
| inv_valid | output | 1 | Invalidate request valid |
| inv_ready | input | 1 | Invalidate request accepted |
| inv_addr | output | 32 | Virtual page address to invalidate |

## Verification
A cursor that skips or repeats an entry shows up at once on the read-address outputs and changes the busy length away from 128 plus the stall count. A latched ID that is wrong, or a selection decode that is wrong, shows up as a request stream that differs from the one predicted from the bench's own table, starting with the first entry that is affected. A stall that is handled wrongly shows up within one cycle as a changed address, or as a request that drops while `inv_ready` is low. A start that is not properly gated shows up as a second walk or as extra requests after `done`.

// File: rtl/flush_scan_pkg.sv
package flush_scan_pkg;

   function automatic bit fs_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int fs_width(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/flush_scan_cursor.sv
module flush_scan_cursor #(
   parameter int NUM_ENTRIES = 128,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)       idx <= '0;
      else if (clear)   idx <= '0;
      else if (advance) idx <= idx + 1'b1;
   end

   assign last = (idx == LAST_IDX);
endmodule

// File: rtl/flush_scan_match.sv
module flush_scan_match #(
   parameter int WORD_W     = 32,
   parameter int PID_W      = 8,
   parameter int PAGE_SHIFT = 13,
   parameter int VALID_BIT  = 3,
   parameter int GLOBAL_BIT = 4
) (
   input  logic [WORD_W-1:0] ent_hi,
   input  logic [WORD_W-1:0] ent_lo,
   input  logic [PID_W-1:0]  pid,
   output logic              hit,
   output logic [WORD_W-1:0] page_addr
);
   localparam int VPN_W = WORD_W - PAGE_SHIFT;

   logic             ent_valid;
   logic             ent_global;
   logic [PID_W-1:0] ent_pid;
   logic [VPN_W-1:0] ent_vpn;

   assign ent_valid  = ent_lo[VALID_BIT];
   assign ent_global = ent_lo[GLOBAL_BIT];
   assign ent_pid    = ent_hi[PID_W-1:0];
   assign ent_vpn    = ent_hi[WORD_W-1:PAGE_SHIFT];

   assign hit       = ent_valid && !ent_global && (ent_pid == pid);
   assign page_addr = {ent_vpn, {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/pid_flush_scanner.sv
module pid_flush_scanner
   import flush_scan_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int PID_REG_W  = 32,
   parameter int PID_W      = 8,
   parameter int PAGE_SHIFT = 13,
   parameter int NUM_TLBS   = 2,
   parameter int NUM_WAYS   = 4,
   parameter int NUM_SETS   = 16,
   parameter int VALID_BIT  = 3,
   parameter int GLOBAL_BIT = 4,
   localparam int TLB_W = fs_width(NUM_TLBS),
   localparam int WAY_W = fs_width(NUM_WAYS),
   localparam int SET_W = fs_width(NUM_SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PID_REG_W-1:0] start_pid,
   output logic              busy,
   output logic              done,
   output logic [TLB_W-1:0]  rd_tlb,
   output logic [WAY_W-1:0]  rd_way,
   output logic [SET_W-1:0]  rd_set,
   input  logic [WORD_W-1:0] rd_hi,
   input  logic [WORD_W-1:0] rd_lo,
   output logic              inv_valid,
   input  logic              inv_ready,
   output logic [WORD_W-1:0] inv_addr
);
   localparam int NUM_ENTRIES = NUM_TLBS * NUM_WAYS * NUM_SETS;
   localparam int IDX_W       = $clog2(NUM_ENTRIES);

   // elaboration-time parameter checks
   if (!fs_is_pow2(NUM_TLBS) || !fs_is_pow2(NUM_WAYS) || !fs_is_pow2(NUM_SETS)) begin : g_bad_geom
      $error("TLB geometry must be powers of two");
   end
   if (NUM_WAYS < 2 || NUM_SETS < 2) begin : g_bad_small
      $error("NUM_WAYS and NUM_SETS must be at least 2");
   end
   if (PID_W > PID_REG_W || PID_W >= PAGE_SHIFT || PAGE_SHIFT >= WORD_W) begin : g_bad_fields
      $error("field widths inconsistent");
   end
   if (VALID_BIT >= WORD_W || GLOBAL_BIT >= WORD_W || VALID_BIT == GLOBAL_BIT) begin : g_bad_flags
      $error("flag bit positions invalid");
   end

   logic             busy_q;
   logic             done_q;
   logic [PID_W-1:0] pid_q;
   logic [IDX_W-1:0] idx;
   logic             last;
   logic             hit;
   logic             advance;
   logic             accept;
   logic [WORD_W-1:0] page_addr;

   assign accept  = start && !busy_q;
   assign advance = busy_q && (!hit || inv_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pid_q  <= '0;
      end else begin
         done_q <= advance && last;
         if (accept) begin
            busy_q <= 1'b1;
            pid_q  <= start_pid[PID_W-1:0];
         end else if (advance && last) begin
            busy_q <= 1'b0;
         end
      end
   end

   flush_scan_cursor #(.NUM_ENTRIES(NUM_ENTRIES)) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .advance (advance),
      .idx     (idx),
      .last    (last)
   );

   flush_scan_match #(
      .WORD_W     (WORD_W),
      .PID_W      (PID_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .VALID_BIT  (VALID_BIT),
      .GLOBAL_BIT (GLOBAL_BIT)
   ) u_match (
      .ent_hi    (rd_hi),
      .ent_lo    (rd_lo),
      .pid       (pid_q),
      .hit       (hit),
      .page_addr (page_addr)
   );

   // index layout: {tlb, way, set}, set innermost
   assign rd_set = idx[SET_W-1:0];
   assign rd_way = idx[SET_W +: WAY_W];
   if (NUM_TLBS > 1) begin : g_multi_tlb
      assign rd_tlb = idx[SET_W+WAY_W +: TLB_W];
   end else begin : g_single_tlb
      assign rd_tlb = '0;
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign inv_valid = busy_q && hit;
   assign inv_addr  = page_addr;
endmodule

// File: rtl/pid_flush_scanner_chk.sv
module pid_flush_scanner_chk #(
   parameter int WORD_W = 32,
   parameter int TLB_W  = 1,
   parameter int WAY_W  = 2,
   parameter int SET_W  = 4,
   parameter int PAGE_SHIFT = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              inv_valid,
   input logic              inv_ready,
   input logic [WORD_W-1:0] inv_addr,
   input logic [TLB_W-1:0]  rd_tlb,
   input logic [WAY_W-1:0]  rd_way,
   input logic [SET_W-1:0]  rd_set
);
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !inv_valid); // R1
   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R2
   AST_REQ_INSIDE_WALK: assert property (@(posedge clk) disable iff (!rst_n) inv_valid |-> busy); // R4
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) inv_valid |-> (inv_addr[PAGE_SHIFT-1:0] == '0)); // R5
   AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) inv_valid && !inv_ready |=> inv_valid && $stable(inv_addr)); // R6
   AST_HOLD_CURSOR: assert property (@(posedge clk) disable iff (!rst_n) inv_valid && !inv_ready |=> $stable({rd_tlb, rd_way, rd_set})); // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) busy && start && !done |=> $stable({rd_tlb, rd_way, rd_set}) || $past(!inv_valid || inv_ready)); // R8
endmodule

bind pid_flush_scanner pid_flush_scanner_chk #(
   .WORD_W(WORD_W), .TLB_W(TLB_W), .WAY_W(WAY_W), .SET_W(SET_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr),
   .rd_tlb(rd_tlb), .rd_way(rd_way), .rd_set(rd_set)
);

// File: tb/tb_pid_flush_scanner.sv
module tb_pid_flush_scanner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_pid = '0;
   logic        busy, done, inv_valid;
   logic        inv_ready = 1'b1;
   logic [31:0] inv_addr, rd_hi, rd_lo;
   logic [0:0]  rd_tlb;
   logic [1:0]  rd_way;
   logic [3:0]  rd_set;

   int checks = 0;
   int failures = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk; // 50 MHz

   pid_flush_scanner dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_pid(start_pid),
      .busy(busy), .done(done), .rd_tlb(rd_tlb), .rd_way(rd_way), .rd_set(rd_set),
      .rd_hi(rd_hi), .rd_lo(rd_lo), .inv_valid(inv_valid), .inv_ready(inv_ready),
      .inv_addr(inv_addr)
   );

   // bench TLB table, computed from the entry number n = {tlb, way, set}
   function automatic logic [18:0] ent_vpn(input int n);
      return 19'((n * 1237 + 677) % 524288);
   endfunction
   function automatic logic [7:0] ent_pid(input int n);
      return ((n % 5) == 0) ? 8'hA5 : 8'(n % 5);
   endfunction
   function automatic logic ent_valid(input int n);
      return (n % 3) != 0;
   endfunction
   function automatic logic ent_global(input int n);
      return (n % 7) == 2;
   endfunction
   function automatic logic [31:0] ent_hi(input int n);
      return {ent_vpn(n), 5'(n), ent_pid(n)};
   endfunction
   function automatic logic [31:0] ent_lo(input int n);
      return {19'(n * 31 + 3), 8'h5A, ent_global(n), ent_valid(n), 3'(n)};
   endfunction

   always_comb begin
      rd_hi = ent_hi(int'({rd_tlb, rd_way, rd_set}));
      rd_lo = ent_lo(int'({rd_tlb, rd_way, rd_set}));
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [31:0] exp_addr [128];

   task automatic run_scan(input logic [31:0] pid, input int mode,
                           input bit inject, input logic [31:0] inj_pid, input string tag);
      int exp_n = 0;
      int got = 0, cyc = 0, stalls = 0, k = 0;
      int bad_idx = 0, bad_addr = 0, bad_hold = 0, extra = 0;
      bit fin = 0, busy_at_done = 0, prev_stall = 0;
      logic [31:0] prev_addr = '0;
      // R4: valid (lo[3]) set, global (lo[4]) clear, hi[7:0] equal to pid[7:0]
      for (int n = 0; n < 128; n++)
         if (ent_valid(n) && !ent_global(n) && ent_pid(n) == pid[7:0])
            exp_addr[exp_n++] = {ent_vpn(n), 13'b0};
      @(negedge clk);
      start = 1'b1; start_pid = pid;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
      while (!fin && cyc < 2000) begin
         inv_ready = (mode == 0) ? 1'b1 : lfsr[0];
         start = inject && (cyc == 10);
         start_pid = inj_pid;
         #1;
         if (done) begin
            fin = 1;
            busy_at_done = busy;
         end else if (busy) begin
            cyc++;
            if (int'({rd_tlb, rd_way, rd_set}) != k) bad_idx++;
            if (prev_stall && (!inv_valid || inv_addr != prev_addr)) bad_hold++;
            prev_stall = 0;
            if (inv_valid) begin
               if (inv_ready) begin
                  if (got >= exp_n) extra++;
                  else if (inv_addr != exp_addr[got]) bad_addr++;
                  got++;
               end else begin
                  stalls++;
                  prev_stall = 1;
                  prev_addr = inv_addr;
               end
            end
            if (!inv_valid || inv_ready) k++;
         end
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      start = 1'b0;
      inv_ready = 1'b1;
      check(got == exp_n && extra == 0, "R4", {tag, " request count"}, got, exp_n);
      check(bad_addr == 0, "R5", {tag, " request addresses"}, bad_addr, 0);
      check(bad_idx == 0, "R3", {tag, " visit order"}, bad_idx, 0);
      check(cyc == 128 + stalls, "R3", {tag, " busy length"}, cyc, 128 + stalls);
      check(bad_hold == 0, "R6", {tag, " stalled request held"}, bad_hold, 0);
      check(fin && !busy_at_done, "R7", {tag, " done with busy low"}, busy_at_done, 0);
      #1;
      check(!done, "R7", {tag, " done lasts one cycle"}, done, 0);
      check(!busy, "R8", {tag, " no second walk"}, busy, 0);
      if (mode != 0)
         check(stalls > 0, "R6", {tag, " stalls exercised"}, stalls, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !inv_valid, "R1", "reset state", {busy, done, inv_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !inv_valid, "R1", "idle after reset", {busy, done, inv_valid}, 0);
      run_scan(32'h0000_0001, 0, 1'b0, '0, "pid1");
      run_scan(32'h1234_5602, 1, 1'b0, '0, "masked pid2");
      run_scan(32'h0000_00A5, 1, 1'b0, '0, "pidA5");
      run_scan(32'h0000_0003, 0, 1'b1, 32'h0000_0004, "pid3 with restart");
      run_scan(32'hFFFF_FF09, 0, 1'b0, '0, "pid9 none");
      run_scan(32'h0000_0004, 1, 1'b1, 32'h0000_0001, "pid4 stalled restart");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule